// File: doc/BRIEF.md
# Conditional Branch Resolver

This block decides whether a branch is taken and where it goes, for a core whose 24-bit program counter steps by 2 per instruction. In one cycle it tests a 4-bit condition code against the N, Z, V and C status flags. It then forms the destination from one of two sources: a halfword-scaled signed displacement, which up to two prefix words can widen, or a base register value taken as a signed offset.

All results are registered and appear one cycle after `br_valid_i`, for exactly one cycle. Besides the taken bit and the target, the block reports what the fetch side does with the instruction it has already fetched behind the branch. A delayed branch always lets that slot instruction run. A non-delayed branch that is taken flushes it.

Top module: `bru_branch_unit`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `res_valid_o`, `taken_o`, `flush_o` and `slot_run_o` are 0 and `target_o` is 0.
- R2: With no prefix (`pfx_cnt_i` = 0), `target_o` equals `pc_i` + 2 + 2 × the 7-bit signed `disp_i`, modulo 2^24.
- R3: With one prefix (`pfx_cnt_i` = 1), the offset is the 21-bit signed value {`pfx_first_i`, `disp_i`, 0}, sign-extended and added to `pc_i` + 2, modulo 2^24.
- R4: With `pfx_cnt_i` = 2 or 3, the offset is the 24-bit value {`pfx_first_i`[2:0], `pfx_second_i`, `disp_i`, 0}, added to `pc_i` + 2, modulo 2^24.
- R5: With `reg_mode_i` = 1, the target is `pc_i` + 2 + `base_i` with its bit 0 forced to 0, modulo 2^24. In this mode `disp_i` and both prefixes have no effect on `target_o`.
- R6: Condition code 0 is always taken, whatever the flags. Code 1 (eq) is taken when Z = 1. Code 2 (ne) is taken when Z = 0.
- R7: The signed codes are 3 (gt: !Z & !(N^V)), 4 (ge: !(N^V)), 5 (lt: N^V) and 6 (le: Z | (N^V)).
- R8: The unsigned codes are 7 (ugt: !Z & !C), 8 (uge: !C), 9 (ult: C) and 10 (ule: Z | C).
- R9: Codes 11 to 15 are never taken and never flush, whatever the flags.
- R10: For a delayed branch (`delayed_i` = 1), `slot_run_o` is 1 and `flush_o` is 0, whether or not the branch is taken.
- R11: For a non-delayed branch, `flush_o` equals `taken_o` and `slot_run_o` is 0.
- R12: Results appear in the cycle after `br_valid_i` and last one cycle. In any other cycle `taken_o`, `flush_o` and `slot_run_o` are 0 and `target_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid_i | input | 1 | A branch is presented this cycle |
| pc_i | input | 24 | Address of the branch instruction |
| cc_i | input | 4 | Condition code (encoding in R6 to R9) |
| disp_i | input | 7 | Native signed displacement in halfwords |
| pfx_cnt_i | input | 2 | Number of prefix words before the branch |
| pfx_first_i | input | 13 | Immediate of the first prefix |
| pfx_second_i | input | 13 | Immediate of the second prefix |
| reg_mode_i | input | 1 | Offset comes from the base register |
| base_i | input | 24 | Base register value, used as a signed offset |
| delayed_i | input | 1 | Delayed form of the branch |
| flag_n_i | input | 1 | Negative flag |
| flag_z_i | input | 1 | Zero flag |
| flag_v_i | input | 1 | Overflow flag |
| flag_c_i | input | 1 | Carry flag |
| res_valid_o | output | 1 | A result is presented this cycle |
| taken_o | output | 1 | The branch is taken |
| target_o | output | 24 | Branch destination address |
| slot_run_o | output | 1 | The fetched slot instruction executes |
| flush_o | output | 1 | The fetched slot instruction is discarded |

## Verification
The assertions check on every cycle the invariants that tie the outputs to one another and to the previous cycle's inputs:
- quiet outputs when no result is presented;
- a flush only with a taken branch;
- a slot run and a flush never together;
- a target whose bit 0 matches the branch address;
- code 0 always taken, and reserved codes never taken.

The correctness of each condition formula, of the displacement widening for each prefix count, of the masking of bit 0 of the base, and of wrap-around at the top of the address space can only be shown by the bench. It does this with vectors whose flags, prefixes and addresses are chosen to separate each case.

// File: rtl/bru_pkg.sv
package bru_pkg;

  localparam int unsigned CC_W = 4;

  typedef enum logic [CC_W-1:0] {
    CC_ALWAYS = 4'd0,
    CC_EQ     = 4'd1,
    CC_NE     = 4'd2,
    CC_GT     = 4'd3,
    CC_GE     = 4'd4,
    CC_LT     = 4'd5,
    CC_LE     = 4'd6,
    CC_UGT    = 4'd7,
    CC_UGE    = 4'd8,
    CC_ULT    = 4'd9,
    CC_ULE    = 4'd10
  } cc_e;

  localparam logic [CC_W-1:0] CC_LAST_VALID = 4'd10;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

  // Signed "less than" derived from the sign and overflow flags.
  function automatic logic signed_lt(flags_t f);
    return f.n ^ f.v;
  endfunction

  function automatic logic cond_holds(logic [CC_W-1:0] cc, flags_t f);
    logic lt_s;
    lt_s = signed_lt(f);
    case (cc)
      CC_ALWAYS: return 1'b1;
      CC_EQ:     return f.z;
      CC_NE:     return ~f.z;
      CC_GT:     return ~f.z & ~lt_s;
      CC_GE:     return ~lt_s;
      CC_LT:     return lt_s;
      CC_LE:     return f.z | lt_s;
      CC_UGT:    return ~f.z & ~f.c;
      CC_UGE:    return ~f.c;
      CC_ULT:    return f.c;
      CC_ULE:    return f.z | f.c;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/bru_cond_eval.sv
module bru_cond_eval
  import bru_pkg::*;
(
  input  logic [CC_W-1:0] cc_i,
  input  flags_t          flags_i,
  output logic            take_o,
  output logic            cc_known_o
);

  always_comb begin
    take_o     = cond_holds(cc_i, flags_i);
    cc_known_o = (cc_i <= CC_LAST_VALID);
  end

endmodule

// File: rtl/bru_disp_build.sv
module bru_disp_build #(
  parameter int unsigned PC_W   = 24,
  parameter int unsigned DISP_W = 7,
  parameter int unsigned PFX_W  = 13
) (
  input  logic [DISP_W-1:0] disp_i,
  input  logic [1:0]        pfx_cnt_i,
  input  logic [PFX_W-1:0]  pfx_first_i,
  input  logic [PFX_W-1:0]  pfx_second_i,
  output logic [PC_W-1:0]   offset_o
);

  localparam int unsigned W0   = DISP_W + 1;
  localparam int unsigned W1   = PFX_W + DISP_W + 1;
  localparam int unsigned HI_W = PC_W - W1;

  logic [W0-1:0]   raw0;
  logic [W1-1:0]   raw1;
  logic [PC_W-1:0] off0, off1, off2;

  always_comb begin
    raw0 = {disp_i, 1'b0};
    raw1 = {pfx_first_i, disp_i, 1'b0};
    off0 = {{(PC_W-W0){raw0[W0-1]}}, raw0};
    off1 = {{(PC_W-W1){raw1[W1-1]}}, raw1};
    off2 = {pfx_first_i[HI_W-1:0], pfx_second_i, disp_i, 1'b0};
    case (pfx_cnt_i)
      2'd0:    offset_o = off0;
      2'd1:    offset_o = off1;
      default: offset_o = off2;
    endcase
  end

endmodule

// File: rtl/bru_target_gen.sv
module bru_target_gen #(
  parameter int unsigned PC_W = 24
) (
  input  logic [PC_W-1:0] pc_i,
  input  logic            reg_mode_i,
  input  logic [PC_W-1:0] base_i,
  input  logic [PC_W-1:0] disp_off_i,
  output logic [PC_W-1:0] target_o
);

  localparam logic [PC_W-1:0] STEP = PC_W'(2);
  localparam logic [PC_W-1:0] LSB  = PC_W'(1);

  function automatic logic [PC_W-1:0] add_wrap(logic [PC_W-1:0] a,
                                               logic [PC_W-1:0] b);
    return a + b;
  endfunction

  logic [PC_W-1:0] next_pc;
  logic [PC_W-1:0] sel_off;

  always_comb begin
    next_pc  = add_wrap(pc_i, STEP);
    sel_off  = reg_mode_i ? (base_i & ~LSB) : disp_off_i;
    target_o = add_wrap(next_pc, sel_off);
  end

endmodule

// File: rtl/bru_branch_unit.sv
module bru_branch_unit
  import bru_pkg::*;
#(
  parameter int unsigned PC_W   = 24,
  parameter int unsigned DISP_W = 7,
  parameter int unsigned PFX_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              br_valid_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [CC_W-1:0]   cc_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [1:0]        pfx_cnt_i,
  input  logic [PFX_W-1:0]  pfx_first_i,
  input  logic [PFX_W-1:0]  pfx_second_i,
  input  logic              reg_mode_i,
  input  logic [PC_W-1:0]   base_i,
  input  logic              delayed_i,
  input  logic              flag_n_i,
  input  logic              flag_z_i,
  input  logic              flag_v_i,
  input  logic              flag_c_i,
  output logic              res_valid_o,
  output logic              taken_o,
  output logic [PC_W-1:0]   target_o,
  output logic              slot_run_o,
  output logic              flush_o
);

  flags_t          flags_w;
  logic            take_w;
  logic            cc_known_w;
  logic [PC_W-1:0] disp_off_w;
  logic [PC_W-1:0] target_w;
  logic            take_ev;
  logic            flush_ev;
  logic            slot_ev;

  assign flags_w = '{n: flag_n_i, z: flag_z_i, v: flag_v_i, c: flag_c_i};

  bru_cond_eval u_cond (
    .cc_i       (cc_i),
    .flags_i    (flags_w),
    .take_o     (take_w),
    .cc_known_o (cc_known_w)
  );

  bru_disp_build #(.PC_W(PC_W), .DISP_W(DISP_W), .PFX_W(PFX_W)) u_disp (
    .disp_i       (disp_i),
    .pfx_cnt_i    (pfx_cnt_i),
    .pfx_first_i  (pfx_first_i),
    .pfx_second_i (pfx_second_i),
    .offset_o     (disp_off_w)
  );

  bru_target_gen #(.PC_W(PC_W)) u_tgt (
    .pc_i       (pc_i),
    .reg_mode_i (reg_mode_i),
    .base_i     (base_i),
    .disp_off_i (disp_off_w),
    .target_o   (target_w)
  );

  // Named events for the registers and the assertions.
  assign take_ev  = br_valid_i & take_w & cc_known_w;
  assign slot_ev  = br_valid_i & delayed_i;
  assign flush_ev = take_ev & ~delayed_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid_o <= 1'b0;
      taken_o     <= 1'b0;
      target_o    <= '0;
      slot_run_o  <= 1'b0;
      flush_o     <= 1'b0;
    end else begin
      res_valid_o <= br_valid_i;
      taken_o     <= take_ev;
      target_o    <= br_valid_i ? target_w : '0;
      slot_run_o  <= slot_ev;
      flush_o     <= flush_ev;
    end
  end

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid_o |-> (!taken_o && !flush_o && !slot_run_o && target_o == '0));

  a_r11_flush_needs_taken: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> (taken_o && !slot_run_o));

  a_r10_slot_excludes_flush: assert property (@(posedge clk) disable iff (!rst_n)
    slot_run_o |-> (!flush_o && res_valid_o));

  a_r2_target_parity: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |-> (target_o[0] == $past(pc_i[0])));

  a_r6_always_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && $past(cc_i) == CC_ALWAYS) |-> taken_o);

  a_r9_reserved_never: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && $past(cc_i) > CC_LAST_VALID) |-> (!taken_o && !flush_o));

endmodule

// File: tb/sim_bru_branch_unit.sv
module sim_bru_branch_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        br_valid_i = 1'b0;
  logic [23:0] pc_i = '0;
  logic [3:0]  cc_i = '0;
  logic [6:0]  disp_i = '0;
  logic [1:0]  pfx_cnt_i = '0;
  logic [12:0] pfx_first_i = '0;
  logic [12:0] pfx_second_i = '0;
  logic        reg_mode_i = 1'b0;
  logic [23:0] base_i = '0;
  logic        delayed_i = 1'b0;
  logic        flag_n_i = 1'b0, flag_z_i = 1'b0, flag_v_i = 1'b0, flag_c_i = 1'b0;
  logic        res_valid_o, taken_o, slot_run_o, flush_o;
  logic [23:0] target_o;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  bru_branch_unit u0 (
    .clk(clk), .rst_n(rst_n), .br_valid_i(br_valid_i), .pc_i(pc_i),
    .cc_i(cc_i), .disp_i(disp_i), .pfx_cnt_i(pfx_cnt_i),
    .pfx_first_i(pfx_first_i), .pfx_second_i(pfx_second_i),
    .reg_mode_i(reg_mode_i), .base_i(base_i), .delayed_i(delayed_i),
    .flag_n_i(flag_n_i), .flag_z_i(flag_z_i), .flag_v_i(flag_v_i),
    .flag_c_i(flag_c_i), .res_valid_o(res_valid_o), .taken_o(taken_o),
    .target_o(target_o), .slot_run_o(slot_run_o), .flush_o(flush_o)
  );

  // Flags nibble is {N, Z, V, C}.
  typedef struct packed {
    logic [23:0] pc;
    logic [3:0]  cc;
    logic [6:0]  d7;
    logic [1:0]  nx;
    logic [12:0] x1;
    logic [12:0] x2;
    logic        regm;
    logic [23:0] base;
    logic        dly;
    logic [3:0]  flg;
    logic        exp_tk;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{24'h000100, 4'd0,  7'h05, 2'd0, 13'h0,    13'h0,    1'b0, 24'h0,      1'b0, 4'b0000, 1'b1}, // R6 always, R2
    '{24'h000100, 4'd1,  7'h7F, 2'd0, 13'h0,    13'h0,    1'b0, 24'h0,      1'b0, 4'b0100, 1'b1}, // R6 eq, R2 neg
    '{24'h000100, 4'd2,  7'h7F, 2'd0, 13'h0,    13'h0,    1'b0, 24'h0,      1'b0, 4'b0100, 1'b0}, // R6 ne
    '{24'h001000, 4'd3,  7'h00, 2'd1, 13'h0001, 13'h0,    1'b0, 24'h0,      1'b0, 4'b0000, 1'b1}, // R7 gt, R3
    '{24'h123456, 4'd4,  7'h7F, 2'd2, 13'h0007, 13'h1FFF, 1'b0, 24'h0,      1'b0, 4'b1010, 1'b1}, // R7 ge, R4
    '{24'hFFFFFE, 4'd5,  7'h00, 2'd0, 13'h0,    13'h0,    1'b0, 24'h0,      1'b1, 4'b1000, 1'b1}, // R7 lt, R2 wrap, R10
    '{24'h000300, 4'd6,  7'h03, 2'd0, 13'h0,    13'h0,    1'b0, 24'h0,      1'b1, 4'b0001, 1'b0}, // R7 le, R10
    '{24'h000200, 4'd7,  7'h55, 2'd2, 13'h1ABC, 13'h0F0F, 1'b1, 24'h000011, 1'b0, 4'b0000, 1'b1}, // R8 ugt, R5
    '{24'h000200, 4'd8,  7'h01, 2'd0, 13'h0,    13'h0,    1'b0, 24'h0,      1'b0, 4'b0001, 1'b0}, // R8 uge
    '{24'h000400, 4'd9,  7'h22, 2'd1, 13'h0444, 13'h0,    1'b1, 24'hFFFFFF, 1'b0, 4'b0001, 1'b1}, // R8 ult, R5
    '{24'h000000, 4'd10, 7'h00, 2'd3, 13'h0000, 13'h0001, 1'b0, 24'h0,      1'b0, 4'b0100, 1'b1}, // R8 ule, R4
    '{24'h000500, 4'd15, 7'h10, 2'd0, 13'h0,    13'h0,    1'b0, 24'h0,      1'b0, 4'b1111, 1'b0}, // R9
    '{24'h000100, 4'd1,  7'h40, 2'd1, 13'h1FFF, 13'h0,    1'b0, 24'h0,      1'b0, 4'b0000, 1'b0}, // R3 neg, R11
    '{24'h000600, 4'd12, 7'h10, 2'd0, 13'h0,    13'h0,    1'b0, 24'h0,      1'b1, 4'b1111, 1'b0}  // R9, R10
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] model_target(vec_t t);
    int off;
    if (t.regm) off = int'($signed(t.base)) & ~1;
    else if (t.nx == 2'd0) off = int'($signed(t.d7)) * 2;
    else if (t.nx == 2'd1) off = int'($signed({t.x1, t.d7})) * 2;
    else off = int'($signed({t.x1[2:0], t.x2, t.d7})) * 2;
    return 24'(int'(t.pc) + 2 + off);
  endfunction

  function automatic string tgt_req(vec_t t);
    if (t.regm) return "R5";
    if (t.nx == 2'd0) return "R2";
    if (t.nx == 2'd1) return "R3";
    return "R4";
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1: outputs idle under reset
    chk(!res_valid_o && !taken_o && !flush_o && !slot_run_o && target_o == '0,
        "R1", int'(target_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!res_valid_o && !taken_o && target_o == '0, "R1", int'(res_valid_o), 0);

    for (int i = 0; i < NV; i++) begin
      vec_t t;
      logic [23:0] et;
      t = VEC[i];
      pc_i = t.pc; cc_i = t.cc; disp_i = t.d7; pfx_cnt_i = t.nx;
      pfx_first_i = t.x1; pfx_second_i = t.x2; reg_mode_i = t.regm;
      base_i = t.base; delayed_i = t.dly;
      {flag_n_i, flag_z_i, flag_v_i, flag_c_i} = t.flg;
      br_valid_i = 1'b1;
      @(negedge clk);
      br_valid_i = 1'b0;
      et = model_target(t);
      chk(res_valid_o == 1'b1, "R12", int'(res_valid_o), 1);
      chk(taken_o == t.exp_tk, (t.cc > 4'd10) ? "R9" : (t.cc >= 4'd7) ? "R8" :
          (t.cc >= 4'd3) ? "R7" : "R6", int'(taken_o), int'(t.exp_tk));
      chk(target_o == et, tgt_req(t), int'(target_o), int'(et));
      if (t.dly) begin
        chk(slot_run_o && !flush_o, "R10", int'({slot_run_o, flush_o}), 2);
      end else begin
        chk(!slot_run_o && flush_o == t.exp_tk, "R11",
            int'({slot_run_o, flush_o}), int'({1'b0, t.exp_tk}));
      end
      // R12: result lasts one cycle
      @(negedge clk);
      chk(!res_valid_o && !taken_o && !flush_o && !slot_run_o && target_o == '0,
          "R12", int'(target_o), 0);
    end

    // R12: two back-to-back branches give two consecutive results
    cc_i = 4'd0; pc_i = 24'h000800; disp_i = 7'h00; pfx_cnt_i = 2'd0;
    reg_mode_i = 1'b0; delayed_i = 1'b0; br_valid_i = 1'b1;
    @(negedge clk);
    chk(res_valid_o && taken_o && target_o == 24'h000802, "R12", int'(target_o), 'h802);
    pc_i = 24'h000900; disp_i = 7'h02;
    @(negedge clk);
    br_valid_i = 1'b0;
    chk(res_valid_o && target_o == 24'h000906, "R2", int'(target_o), 'h906);

    // R1: reset while a result is presented clears it
    br_valid_i = 1'b1;
    @(negedge clk);
    br_valid_i = 1'b0;
    rst_n = 1'b0;
    #1;
    chk(!res_valid_o && !taken_o && target_o == '0, "R1", int'(taken_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule